// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block is the register core of an eight-pin general purpose I/O expander. A serial front-end, which is not part of this block, decodes bus transactions into a 2-bit register pointer, a single-cycle write strobe with its data byte, and a read of the register the pointer selects. The block holds three writable registers: output drive values, an input polarity mask and pin directions. It also presents a read-only view of the pin levels.

Each pin has a drive value and an output enable for the pad, and a sampled input level coming back from it. The incoming levels pass through a synchronizer, so pins may change at any time relative to the clock. The input view always shows the synchronized pin level, whatever the pin's direction, XORed with the polarity mask. A read of the output register returns the stored value, not what is on the pin. Writes aimed at the input view are dropped.

Top module: `gpx_regbank`

## Requirements
- R1: The pointer selects a register: code 0 is the input view, 1 the output drive register, 2 the polarity mask and 3 the direction register.
- R2: While reset is high, and after its release until the first write, the drive register reads 0xFF, the polarity mask reads 0x00 and the direction register reads 0xFF. `pin_out` is 0xFF and `pin_oe` is 0x00.
- R3: A direction bit of 1 makes its pin an input, with `pin_oe` bit low. A direction bit of 0 makes it an output, with `pin_oe` bit high and `pin_out` bit equal to the matching drive register bit. `pin_oe` is the bitwise inverse of the direction register.
- R4: A read of code 0 returns the synchronized pin levels for every pin, whether that pin is set as input or output.
- R5: On a read of code 0, each polarity bit that is 1 inverts the matching pin bit, and each bit that is 0 passes it unchanged.
- R6: A read of code 1 returns the stored drive register, even when the pin levels differ from it.
- R7: A write with code 0 changes no register: every readback, `pin_out` and `pin_oe` stay as they were.
- R8: A write takes effect on the rising edge where `wr_en` is high. Before that edge `pin_out` and `pin_oe` hold their old values, and with `wr_en` low no register changes.
- R9: `rd_data` is registered: it shows the register the pointer selected in the previous cycle. A pin change reaches `rd_data` on the third rising edge after it, through two synchronizer stages and the read register.
- R10: The polarity mask affects only the input view. Drive register readback, `pin_out` and `pin_oe` do not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr | input | 2 | Register pointer (0 input view, 1 drive, 2 polarity, 3 direction) |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data of the register selected in the previous cycle |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| pin_out | output | 8 | Drive value for each pin |
| pin_oe | output | 8 | Output enable for each pin, high when driving |

## Verification
The assertions assume that `ptr`, `wr_en` and `wr_data` are synchronous to `clk` and are stable at each rising edge. They also assume that `wr_en` is a strobe whose data and pointer belong to the same cycle. The bench meets these assumptions by changing bus inputs only just after a falling edge. It changes `pin_in` freely, because that input is synchronized. The readback assertions apply only in cycles with no write, since a write and a read in the same cycle return the old value. The bench checks that same-cycle case only through the pin outputs.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic [1:0] {
    PTR_IN  = 2'd0,
    PTR_OUT = 2'd1,
    PTR_POL = 2'd2,
    PTR_CFG = 2'd3
  } gpx_ptr_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int         W       = 8,
  parameter logic [W-1:0] OUT_RST = '1,
  parameter logic [W-1:0] POL_RST = '0,
  parameter logic [W-1:0] CFG_RST = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   ptr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] out_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] cfg_q
);
  logic wr_out, wr_pol, wr_cfg;

  always_comb begin
    wr_out = 1'b0;
    wr_pol = 1'b0;
    wr_cfg = 1'b0;
    if (wr_en) begin
      case (gpx_ptr_e'(ptr))
        PTR_OUT: wr_out = 1'b1;
        PTR_POL: wr_pol = 1'b1;
        PTR_CFG: wr_cfg = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= OUT_RST;
      pol_q <= POL_RST;
      cfg_q <= CFG_RST;
    end else begin
      if (wr_out) out_q <= wr_data;
      if (wr_pol) pol_q <= wr_data;
      if (wr_cfg) cfg_q <= wr_data;
    end
  end
endmodule

// File: rtl/gpx_rdmux.sv
module gpx_rdmux
  import gpx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   ptr,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] pol_q,
  input  logic [W-1:0] cfg_q,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] sel;

  always_comb begin
    case (gpx_ptr_e'(ptr))
      PTR_IN:  sel = pin_sync ^ pol_q;
      PTR_OUT: sel = out_q;
      PTR_POL: sel = pol_q;
      default: sel = cfg_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   ptr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] out_q, pol_q, cfg_q;

  gpx_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpx_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q)
  );

  gpx_rdmux #(.W(W)) u_rdmux (
    .clk(clk), .rst(rst), .ptr(ptr), .pin_sync(pin_sync),
    .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q), .rd_data(rd_data)
  );

  // Each pin drives only when its direction bit is cleared.
  assign pin_out = out_q;
  assign pin_oe  = ~cfg_q;
endmodule

// File: rtl/gpx_regbank_chk.sv
module gpx_regbank_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   ptr,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe
);
  assert_reset_pins_R2: assert property (@(posedge clk)
    rst |=> (pin_out == '1) && (pin_oe == '0));

  assert_drive_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ptr == 2'd1) |=> pin_out == $past(wr_data));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ptr == 2'd3) |=> pin_oe == ~$past(wr_data));

  assert_drive_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || ptr == 2'd0 || ptr == 2'd2) |=> $stable(pin_out));

  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || ptr == 2'd0 || ptr == 2'd1 || ptr == 2'd2) |=> $stable(pin_oe));

  assert_drive_readback_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && ptr == 2'd1) |=> rd_data == pin_out);

  assert_dir_readback_R1: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && ptr == 2'd3) |=> rd_data == ~pin_oe);
endmodule

bind gpx_regbank gpx_regbank_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpx_regbank_tb.sv
module gpx_regbank_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ptr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] rd_data, pin_out, pin_oe;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpx_regbank u_dut (
    .clk(clk), .rst(rst), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected read result per strobe from the driver.
  always @(negedge clk) begin
    if (pend) begin
      chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      pend = 1'b0;
    end
  end

  task automatic rd(input logic [1:0] p, input logic [7:0] exp, input string tag);
    @(negedge clk);
    ptr = p;
    wr_en = 1'b0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    pend = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    ptr = p;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 pin_out in reset", pin_out, 8'hFF);
    chk("R2 pin_oe in reset", pin_oe, 8'h00);
    rst = 1'b0;
    rd(2'd1, 8'hFF, "R2 R1 drive default");
    rd(2'd2, 8'h00, "R2 R1 polarity default");
    rd(2'd3, 8'hFF, "R2 R1 direction default");

    pin_in = 8'hA5;
    repeat (4) @(negedge clk);
    rd(2'd0, 8'hA5, "R4 R1 input view all inputs");

    // R8: value holds before the strobe edge, changes after it
    @(negedge clk);
    ptr = 2'd1; wr_data = 8'h3C; wr_en = 1'b1;
    #1;
    chk("R8 pin_out before edge", pin_out, 8'hFF);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 pin_out after edge", pin_out, 8'h3C);
    chk("R3 pin_oe all inputs", pin_oe, 8'h00);
    repeat (2) @(negedge clk);
    chk("R8 no strobe no change", pin_out, 8'h3C);

    wr(2'd3, 8'h0F);
    chk("R3 pin_oe inverse of direction", pin_oe, 8'hF0);
    chk("R3 drive value on pins", pin_out, 8'h3C);
    rd(2'd3, 8'h0F, "R1 direction readback");
    rd(2'd0, 8'hA5, "R4 input view with mixed directions");
    rd(2'd1, 8'h3C, "R6 drive readback not pin level");

    wr(2'd2, 8'hFF);
    rd(2'd0, 8'h5A, "R5 full inversion");
    rd(2'd1, 8'h3C, "R10 drive readback unaffected by polarity");
    chk("R10 pin_out unaffected by polarity", pin_out, 8'h3C);
    chk("R10 pin_oe unaffected by polarity", pin_oe, 8'hF0);
    wr(2'd2, 8'h0F);
    rd(2'd0, 8'hAA, "R5 partial inversion");

    wr(2'd0, 8'h00);
    chk("R7 pin_out after input write", pin_out, 8'h3C);
    chk("R7 pin_oe after input write", pin_oe, 8'hF0);
    rd(2'd1, 8'h3C, "R7 drive after input write");
    rd(2'd2, 8'h0F, "R7 polarity after input write");
    rd(2'd3, 8'h0F, "R7 direction after input write");
    rd(2'd0, 8'hAA, "R7 input view after input write");

    // R9: latency of a pin change with the pointer held at code 0
    wr(2'd2, 8'h00);
    rd(2'd0, 8'hA5, "R9 baseline");
    pin_in = 8'h00;
    @(negedge clk);
    chk("R9 one edge", rd_data, 8'hA5);
    @(negedge clk);
    chk("R9 two edges", rd_data, 8'hA5);
    @(negedge clk);
    chk("R9 three edges", rd_data, 8'h00);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R2 pin_out after second reset", pin_out, 8'hFF);
    chk("R2 pin_oe after second reset", pin_oe, 8'h00);
    rd(2'd2, 8'h00, "R2 polarity after second reset");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule